// File: doc/BRIEF.md
# SCSI Host DMA Channel Controller

This block is a bus-master DMA channel that sits between the byte FIFO of a SCSI core and system memory. Software loads a transfer count and a physical start address, then writes an 8-bit command byte. The channel issues memory beats of up to `BEAT_BYTES` bytes each. It counts the working byte count down and the working address up until the count is exhausted. It reports the outcome in an 8-bit status byte whose bits are sticky. An interrupt-pending output is derived from those bits.

The command byte also carries an abort, which stops the channel at the next beat boundary, and a flush, which pushes residual FIFO bytes to memory. The direction bit is set when data flows from the SCSI device toward memory. When a start is issued, the programmed count is clipped to 64 KiB, or to 16 MiB in extended-count mode. It is clipped further so that the transfer never passes the next 16 MiB address boundary. The SCSI core appears only as two levels: bytes available and bytes of space. A strobe reports how many bytes each completed beat moved.

Top module: `scsi_dma_chan`

## Requirements
- R1: After reset the status byte, command byte, working count and working address all read 0, and `mem_req` and `irq_pending` are low.
- R2: Registers sit at byte offsets 0x40 command, 0x44 start count, 0x48 start address, 0x4C working count, 0x50 working address, 0x54 status, 0x58 list address, and 0x5C working list address. Writes to 0x4C, 0x50, 0x54 and 0x5C are ignored.
- R3: Command bits [1:0] encode 0 = idle, 1 = flush, 2 = abort and 3 = start. A start loads the working address with the start address. It loads the working count with the smallest of three values: the start count, 2^16 (or 2^24 when `wide_count` is high), and 2^24 minus the low 24 bits of the start address.
- R4: Beats carry consecutive addresses beginning at the start address. While `mem_req` is high and `mem_ack` is low, the request, address and size stay unchanged.
- R5: Each transfer beat moves min(`BEAT_BYTES`, remaining count) bytes. Each flush beat moves min(`BEAT_BYTES`, FIFO level) bytes.
- R6: Command bit 7 set gives memory writes (`mem_we`=1), and a beat waits until `fifo_level` covers it. Bit 7 clear gives memory reads, and a beat waits until `fifo_space` covers it.
- R7: `irq_pending` is high when any of status bit 1 (error), bit 2 (aborted), bit 3 (done) or bit 4 (SCSI interrupt) is set. Bit 5 (flush complete) alone does not raise it.
- R8: Status bits stay set until a command write of idle or start clears them.
- R9: An abort issued with a beat outstanding waits for that beat's acknowledge and only then sets status bit 2. After an abort, no further beats are issued.
- R10: A beat acknowledged with `mem_err` sets status bit 1. The beat is not counted, no further beats are issued, and the command byte still reads start.
- R11: A flush writes all FIFO bytes to memory from the working address. It sets status bit 5 once `fifo_level` is 0.
- R12: `scsi_int` high sets status bit 4.
- R13: A start with a clipped length of 0 sets status bit 3 without issuing a beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| wide_count | input | 1 | Extended-count mode (24-bit length limit) |
| fifo_level | input | FIFO_W | Bytes held in the SCSI core FIFO |
| fifo_space | input | FIFO_W | Free bytes in the SCSI core FIFO |
| fifo_xfer | output | 1 | A beat completed without error this cycle |
| fifo_nbytes | output | $clog2(BEAT_BYTES+1) | Bytes moved by that beat |
| scsi_int | input | 1 | Interrupt from the SCSI core |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat writes memory |
| mem_addr | output | 32 | Beat byte address |
| mem_nbytes | output | $clog2(BEAT_BYTES+1) | Beat size in bytes |
| mem_ack | input | 1 | Beat accepted |
| mem_err | input | 1 | Beat failed (valid with `mem_ack`) |
| irq_pending | output | 1 | Interrupt pending |

## Verification
The hardest situation to reach from the ports is an abort that lands while a beat is still outstanding. The bench withholds the memory acknowledge and waits for a request to appear. It then writes abort and confirms that the aborted bit stays clear until the acknowledge is released. The flush path needs a stranded residue: a direction-to-memory transfer is started with fewer FIFO bytes than a full beat requires, so it stalls, and only then is the flush written. Clipping is driven by random counts and addresses, some of them pushed to just below a 16 MiB boundary, and is compared against a bench model.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    localparam int unsigned REG_W   = 32;
    localparam int unsigned CNT_W   = 25;
    localparam int unsigned BOUND_B = 24;
    localparam int unsigned SHORT_B = 16;

    // word index scaled by four gives byte offset
    localparam logic [7:0] OFF_CMD  = 8'h10 << 2;
    localparam logic [7:0] OFF_STC  = 8'h11 << 2;
    localparam logic [7:0] OFF_SPA  = 8'h12 << 2;
    localparam logic [7:0] OFF_WBC  = 8'h13 << 2;
    localparam logic [7:0] OFF_WAC  = 8'h14 << 2;
    localparam logic [7:0] OFF_STAT = 8'h15 << 2;
    localparam logic [7:0] OFF_LST  = 8'h16 << 2;
    localparam logic [7:0] OFF_WLST = 8'h17 << 2;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_FLUSH = 2'd1,
        OP_ABORT = 2'd2,
        OP_START = 2'd3
    } op_e;

    typedef struct packed {
        logic to_mem;
        logic ien_b;
        logic ien_a;
        logic list_en;
        logic spare;
        logic diag;
        op_e  op;
    } cmd_t;

    typedef struct packed {
        logic [1:0] spare;
        logic       flushed;
        logic       core_irq;
        logic       done;
        logic       aborted;
        logic       fault;
        logic       pwr_down;
    } stat_t;

    typedef enum logic [2:0] {
        S_REST,
        S_RUN,
        S_FAULT,
        S_ABWAIT,
        S_HALT,
        S_FLUSH,
        S_DONE
    } state_e;

    function automatic logic [CNT_W-1:0] clip_len(input logic [REG_W-1:0] cnt,
                                                  input logic [REG_W-1:0] addr,
                                                  input logic wide);
        logic [REG_W:0] lim;
        logic [REG_W:0] len;
        logic [REG_W:0] room;
        lim  = wide ? ((REG_W+1)'(1) << BOUND_B) : ((REG_W+1)'(1) << SHORT_B);
        len  = {1'b0, cnt};
        if (len > lim) len = lim;
        room = ((REG_W+1)'(1) << BOUND_B) - (REG_W+1)'(addr[BOUND_B-1:0]);
        if (len > room) len = room;
        return len[CNT_W-1:0];
    endfunction

endpackage

// File: rtl/sdc_regs.sv
module sdc_regs
    import sdc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [7:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [CNT_W-1:0] wcount,
    input  logic [REG_W-1:0] waddr,
    input  stat_t            status,
    output cmd_t             cmd_q,
    output logic [REG_W-1:0] stc_q,
    output logic [REG_W-1:0] spa_q,
    output logic             cmd_wr,
    output op_e              cmd_op,
    output logic             cmd_dir
);

    logic [REG_W-1:0] lst_q;
    cmd_t             cmd_in;

    assign cmd_in  = cmd_t'(reg_wdata[7:0]);
    assign cmd_wr  = reg_we && (reg_addr == OFF_CMD);
    assign cmd_op  = cmd_in.op;
    assign cmd_dir = cmd_in.to_mem;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            stc_q <= '0;
            spa_q <= '0;
            lst_q <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                OFF_CMD: cmd_q <= cmd_in;
                OFF_STC: stc_q <= reg_wdata;
                OFF_SPA: spa_q <= reg_wdata;
                OFF_LST: lst_q <= reg_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (reg_addr)
            OFF_CMD:  reg_rdata = REG_W'(cmd_q);
            OFF_STC:  reg_rdata = stc_q;
            OFF_SPA:  reg_rdata = spa_q;
            OFF_WBC:  reg_rdata = REG_W'(wcount);
            OFF_WAC:  reg_rdata = waddr;
            OFF_STAT: reg_rdata = REG_W'(status);
            OFF_LST:  reg_rdata = lst_q;
            OFF_WLST: reg_rdata = lst_q;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/sdc_engine.sv
module sdc_engine
    import sdc_pkg::*;
#(
    parameter int unsigned BEAT_BYTES = 4,
    parameter int unsigned FIFO_W     = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cmd_wr,
    input  op_e                           cmd_op,
    input  logic                          cmd_dir,
    input  logic [REG_W-1:0]              stc,
    input  logic [REG_W-1:0]              spa,
    input  logic                          wide,
    input  logic [FIFO_W-1:0]             fifo_level,
    input  logic [FIFO_W-1:0]             fifo_space,
    input  logic                          scsi_int,
    input  logic                          mem_ack,
    input  logic                          mem_err,
    output logic                          mem_req,
    output logic                          mem_we,
    output logic [REG_W-1:0]              mem_addr,
    output logic [$clog2(BEAT_BYTES+1)-1:0] mem_nbytes,
    output logic                          fifo_xfer,
    output logic [$clog2(BEAT_BYTES+1)-1:0] fifo_nbytes,
    output logic [CNT_W-1:0]              wcount,
    output logic [REG_W-1:0]              waddr,
    output stat_t                         status
);

    localparam int unsigned BEAT_W = $clog2(BEAT_BYTES + 1);
    localparam logic [BEAT_W-1:0] FULL_BEAT = BEAT_W'(BEAT_BYTES);

    state_e            state_q;
    stat_t             st_q;
    logic [CNT_W-1:0]  wcount_q;
    logic [REG_W-1:0]  waddr_q;
    logic              run_dir_q;
    logic              beat_q;
    logic              beat_we_q;
    logic              beat_stale_q;
    logic [REG_W-1:0]  beat_addr_q;
    logic [BEAT_W-1:0] beat_n_q;

    logic [BEAT_W-1:0] n_run;
    logic [BEAT_W-1:0] n_flush;
    logic              run_ready;
    logic              beat_done;
    logic              count_beat;

    always_comb begin
        if (wcount_q < CNT_W'(BEAT_BYTES)) n_run = wcount_q[BEAT_W-1:0];
        else                               n_run = FULL_BEAT;
        if (fifo_level < FIFO_W'(BEAT_BYTES)) n_flush = fifo_level[BEAT_W-1:0];
        else                                  n_flush = FULL_BEAT;
        run_ready = run_dir_q ? (fifo_level >= FIFO_W'(n_run))
                              : (fifo_space >= FIFO_W'(n_run));
    end

    assign beat_done  = beat_q && mem_ack;
    assign count_beat = beat_done && !mem_err && !beat_stale_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= S_REST;
            st_q         <= '0;
            wcount_q     <= '0;
            waddr_q      <= '0;
            run_dir_q    <= 1'b0;
            beat_q       <= 1'b0;
            beat_we_q    <= 1'b0;
            beat_stale_q <= 1'b0;
            beat_addr_q  <= '0;
            beat_n_q     <= '0;
        end else begin
            if (scsi_int) st_q.core_irq <= 1'b1;

            // completion of an outstanding beat
            if (beat_done) begin
                beat_q <= 1'b0;
                if (count_beat) begin
                    if (state_q == S_RUN || state_q == S_ABWAIT) begin
                        wcount_q <= wcount_q - CNT_W'(beat_n_q);
                        waddr_q  <= waddr_q + REG_W'(beat_n_q);
                    end else if (state_q == S_FLUSH) begin
                        waddr_q  <= waddr_q + REG_W'(beat_n_q);
                    end
                end
                if (mem_err && state_q == S_RUN) begin
                    st_q.fault <= 1'b1;
                    state_q    <= S_FAULT;
                end
                if (state_q == S_ABWAIT) begin
                    if (mem_err) st_q.fault <= 1'b1;
                    st_q.aborted <= 1'b1;
                    state_q      <= S_HALT;
                end
            end

            // beat issue, only between beats and never under a command write
            if (!beat_q && !cmd_wr) begin
                case (state_q)
                    S_RUN: begin
                        if (wcount_q == '0) begin
                            st_q.done <= 1'b1;
                            state_q   <= S_DONE;
                        end else if (run_ready) begin
                            beat_q       <= 1'b1;
                            beat_we_q    <= run_dir_q;
                            beat_addr_q  <= waddr_q;
                            beat_n_q     <= n_run;
                            beat_stale_q <= 1'b0;
                        end
                    end
                    S_FLUSH: begin
                        if (fifo_level == '0) begin
                            st_q.flushed <= 1'b1;
                        end else begin
                            beat_q       <= 1'b1;
                            beat_we_q    <= 1'b1;
                            beat_addr_q  <= waddr_q;
                            beat_n_q     <= n_flush;
                            beat_stale_q <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end

            // command writes take priority over the lines above
            if (cmd_wr) begin
                case (cmd_op)
                    OP_IDLE: begin
                        st_q    <= '0;
                        state_q <= S_REST;
                        if (beat_q && !mem_ack) beat_stale_q <= 1'b1;
                    end
                    OP_START: begin
                        st_q      <= '0;
                        wcount_q  <= clip_len(stc, spa, wide);
                        waddr_q   <= spa;
                        run_dir_q <= cmd_dir;
                        state_q   <= S_RUN;
                        if (beat_q && !mem_ack) beat_stale_q <= 1'b1;
                    end
                    OP_ABORT: begin
                        if (beat_q && !mem_ack) begin
                            state_q <= S_ABWAIT;
                        end else begin
                            st_q.aborted <= 1'b1;
                            state_q      <= S_HALT;
                        end
                    end
                    OP_FLUSH: begin
                        state_q <= S_FLUSH;
                        if (beat_q && !mem_ack) beat_stale_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign mem_req     = beat_q;
    assign mem_we      = beat_we_q;
    assign mem_addr    = beat_addr_q;
    assign mem_nbytes  = beat_n_q;
    assign fifo_xfer   = beat_done && !mem_err;
    assign fifo_nbytes = beat_n_q;
    assign wcount      = wcount_q;
    assign waddr       = waddr_q;
    assign status      = st_q;

endmodule

// File: rtl/scsi_dma_chan.sv
module scsi_dma_chan
    import sdc_pkg::*;
#(
    parameter int unsigned BEAT_BYTES = 4,
    parameter int unsigned FIFO_W     = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            reg_we,
    input  logic [7:0]                      reg_addr,
    input  logic [31:0]                     reg_wdata,
    output logic [31:0]                     reg_rdata,
    input  logic                            wide_count,
    input  logic [FIFO_W-1:0]               fifo_level,
    input  logic [FIFO_W-1:0]               fifo_space,
    output logic                            fifo_xfer,
    output logic [$clog2(BEAT_BYTES+1)-1:0] fifo_nbytes,
    input  logic                            scsi_int,
    output logic                            mem_req,
    output logic                            mem_we,
    output logic [31:0]                     mem_addr,
    output logic [$clog2(BEAT_BYTES+1)-1:0] mem_nbytes,
    input  logic                            mem_ack,
    input  logic                            mem_err,
    output logic                            irq_pending
);

    cmd_t             cmd_w;
    stat_t            status_w;
    logic [REG_W-1:0] stc_w;
    logic [REG_W-1:0] spa_w;
    logic [CNT_W-1:0] wcount_w;
    logic [REG_W-1:0] waddr_w;
    logic             cmd_wr_w;
    op_e              cmd_op_w;
    logic             cmd_dir_w;

    sdc_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .wcount    (wcount_w),
        .waddr     (waddr_w),
        .status    (status_w),
        .cmd_q     (cmd_w),
        .stc_q     (stc_w),
        .spa_q     (spa_w),
        .cmd_wr    (cmd_wr_w),
        .cmd_op    (cmd_op_w),
        .cmd_dir   (cmd_dir_w)
    );

    sdc_engine #(
        .BEAT_BYTES (BEAT_BYTES),
        .FIFO_W     (FIFO_W)
    ) u_engine (
        .clk         (clk),
        .rst         (rst),
        .cmd_wr      (cmd_wr_w),
        .cmd_op      (cmd_op_w),
        .cmd_dir     (cmd_dir_w),
        .stc         (stc_w),
        .spa         (spa_w),
        .wide        (wide_count),
        .fifo_level  (fifo_level),
        .fifo_space  (fifo_space),
        .scsi_int    (scsi_int),
        .mem_ack     (mem_ack),
        .mem_err     (mem_err),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_nbytes  (mem_nbytes),
        .fifo_xfer   (fifo_xfer),
        .fifo_nbytes (fifo_nbytes),
        .wcount      (wcount_w),
        .waddr       (waddr_w),
        .status      (status_w)
    );

    assign irq_pending = status_w.fault | status_w.aborted | status_w.done | status_w.core_irq;

endmodule

// File: rtl/sdc_chk.sv
module sdc_chk #(
    parameter int unsigned BEAT_BYTES = 4
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            reg_we,
    input logic                            mem_req,
    input logic                            mem_ack,
    input logic                            mem_we,
    input logic [31:0]                     mem_addr,
    input logic [$clog2(BEAT_BYTES+1)-1:0] mem_nbytes,
    input logic                            scsi_int,
    input logic                            irq_pending,
    input logic [7:0]                      status,
    input logic [7:0]                      cmd
);

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_nbytes));

    // R5
    beat_size_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_nbytes != '0) && (mem_nbytes <= ($clog2(BEAT_BYTES+1))'(BEAT_BYTES)));

    // R6
    dir_sense_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) && (cmd[1:0] == 2'd3) |-> mem_we == cmd[7]);

    // R7
    irq_done_chk: assert property (@(posedge clk) disable iff (rst)
        status[3] |-> irq_pending);

    // R7
    irq_flush_chk: assert property (@(posedge clk) disable iff (rst)
        status[5] && (status[4:1] == 4'd0) |-> !irq_pending);

    // R8
    sticky_done_chk: assert property (@(posedge clk) disable iff (rst)
        status[3] && !reg_we |=> status[3]);

    // R9
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        status[2] && !mem_req && !reg_we |=> !mem_req);

    // R10
    fault_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        status[1] && !mem_req && !reg_we |=> !mem_req);

    // R12
    core_irq_chk: assert property (@(posedge clk) disable iff (rst)
        scsi_int && !reg_we |=> status[4]);

endmodule

bind scsi_dma_chan sdc_chk #(.BEAT_BYTES(BEAT_BYTES)) u_sdc_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_we      (reg_we),
    .mem_req     (mem_req),
    .mem_ack     (mem_ack),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_nbytes  (mem_nbytes),
    .scsi_int    (scsi_int),
    .irq_pending (irq_pending),
    .status      (status_w),
    .cmd         (cmd_w)
);

// File: tb/scsi_dma_chan_bench.sv
module scsi_dma_chan_bench;

    localparam int unsigned BB = 4;
    localparam logic [7:0] A_CMD = 8'h40, A_STC = 8'h44, A_SPA = 8'h48, A_WBC = 8'h4C,
                           A_WAC = 8'h50, A_STAT = 8'h54, A_LST = 8'h58, A_WLST = 8'h5C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        wide_count = 1'b0;
    logic [7:0]  fifo_level;
    logic [7:0]  fifo_space;
    logic        fifo_xfer;
    logic [2:0]  fifo_nbytes;
    logic        scsi_int = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [2:0]  mem_nbytes;
    logic        mem_ack = 1'b0;
    logic        mem_err = 1'b0;
    logic        irq_pending;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // memory / fifo model state
    int          lvl = 0;
    int          spc = 255;
    int          ack_mode = 1;
    bit          err_next = 0;
    bit          flush_mode = 0;
    logic [31:0] exp_addr = 0;
    int          rem = 0;
    bit          exp_we = 0;
    int          beats = 0;
    int          bytes = 0;

    assign fifo_level = 8'(lvl);
    assign fifo_space = 8'(spc);

    always #4 clk = ~clk;

    scsi_dma_chan u_scsi_dma_chan (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .wide_count(wide_count), .fifo_level(fifo_level),
        .fifo_space(fifo_space), .fifo_xfer(fifo_xfer), .fifo_nbytes(fifo_nbytes),
        .scsi_int(scsi_int), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_nbytes(mem_nbytes), .mem_ack(mem_ack), .mem_err(mem_err), .irq_pending(irq_pending)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int min_beat(input int v);
        return (v < BB) ? v : BB;
    endfunction

    function automatic logic [31:0] ref_len(input logic [31:0] cnt, input logic [31:0] addr,
                                            input bit wide);
        longint lim = wide ? 64'd16777216 : 64'd65536;
        longint l = cnt;
        longint room = 64'd16777216 - longint'(addr & 32'h00FF_FFFF);
        if (l > lim) l = lim;
        if (l > room) l = room;
        return 32'(l);
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic idle_wait(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start(input logic [31:0] cnt, input logic [31:0] addr, input bit dir);
        wr(A_CMD, {dir, 7'd0});
        wr(A_STC, cnt);
        wr(A_SPA, addr);
        exp_addr = addr; rem = int'(ref_len(cnt, addr, wide_count)); exp_we = dir;
        beats = 0; bytes = 0; flush_mode = 0;
        wr(A_CMD, {dir, 7'd3});
    endtask

    task automatic wait_done(input int maxc);
        logic [31:0] s;
        for (int i = 0; i < maxc; i++) begin
            rd(A_STAT, s);
            if (s[3]) break;
            @(negedge clk);
        end
    endtask

    // memory responder: acknowledges beats and checks each one
    always @(negedge clk) begin
        if (!rst) begin
            mem_ack = 1'b0;
            mem_err = 1'b0;
            if (mem_req && (ack_mode == 1 || (ack_mode == 2 && $urandom_range(1, 0) == 1))) begin
                mem_ack = 1'b1;
                if (err_next) begin mem_err = 1'b1; err_next = 0; end
                chk("R5 beat size", 32'(mem_nbytes), 32'(flush_mode ? min_beat(lvl) : min_beat(rem)));
                chk("R4 beat address", mem_addr, exp_addr);
                chk("R6 beat direction", 32'(mem_we), 32'(flush_mode ? 1 : exp_we));
                if (!mem_err) begin
                    beats++;
                    bytes += int'(mem_nbytes);
                    exp_addr += 32'(mem_nbytes);
                    if (!flush_mode) rem -= int'(mem_nbytes);
                    if (mem_we) lvl -= int'(mem_nbytes);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] c, a, e;
        bit w;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(A_STAT, v); chk("R1 status", v, 0);
        rd(A_CMD, v);  chk("R1 command", v, 0);
        rd(A_WBC, v);  chk("R1 count", v, 0);
        rd(A_WAC, v);  chk("R1 address", v, 0);
        chk("R1 irq", 32'(irq_pending), 0);
        chk("R1 req", 32'(mem_req), 0);

        // R2 register file and ignored writes
        wr(A_STC, 32'h0000_1234); rd(A_STC, v); chk("R2 count reg", v, 32'h1234);
        wr(A_SPA, 32'hABCD_0000); rd(A_SPA, v); chk("R2 addr reg", v, 32'hABCD_0000);
        wr(A_LST, 32'h55);        rd(A_WLST, v); chk("R2 list reg", v, 32'h55);
        wr(A_WLST, 32'h99);       rd(A_LST, v); chk("R2 list ignored", v, 32'h55);
        wr(A_STAT, 32'hFF);       rd(A_STAT, v); chk("R2 status ignored", v, 0);
        wr(A_WBC, 32'h77);        rd(A_WBC, v); chk("R2 count ignored", v, 0);
        wr(A_WAC, 32'h77);        rd(A_WAC, v); chk("R2 addr ignored", v, 0);

        // R3 clipping (direction to memory, empty fifo: no beats)
        lvl = 0;
        wide_count = 0; start(32'h30000, 32'h1000, 1);
        rd(A_WBC, v); chk("R3 short limit", v, 32'h10000);
        wide_count = 1; start(32'h30000, 32'h1000, 1);
        rd(A_WBC, v); chk("R3 wide limit", v, 32'h30000);
        start(32'h100, 32'h12FF_FFF8, 1);
        rd(A_WBC, v); chk("R3 boundary clip", v, 32'h8);
        rd(A_WAC, v); chk("R3 start address", v, 32'h12FF_FFF8);
        for (int i = 0; i < 24; i++) begin
            case ($urandom_range(2, 0))
                0: c = $urandom;
                1: c = $urandom & 32'h3_FFFF;
                default: c = $urandom & 32'hFF;
            endcase
            a = $urandom;
            if ($urandom_range(1, 0) == 1) a = a | 32'h00FF_FF00;
            wide_count = 1'($urandom_range(1, 0));
            start(c, a, 1);
            rd(A_WBC, v); chk("R3 random clip", v, ref_len(c, a, wide_count));
        end
        wide_count = 0;
        wr(A_CMD, 32'h0);

        // R4 R5 R6 random transfers
        lvl = 255; spc = 255; ack_mode = 2;
        for (int i = 0; i < 10; i++) begin
            c = 32'($urandom_range(40, 1));
            a = $urandom & 32'hFFFF_F000;
            w = 1'($urandom_range(1, 0));
            lvl = 255;
            start(c, a, w);
            wait_done(500);
            chk("R4 bytes moved", 32'(bytes), c);
            rd(A_WBC, v); chk("R4 final count", v, 0);
            rd(A_WAC, v); chk("R4 final address", v, a + c);
            chk("R7 irq after done", 32'(irq_pending), 1);
        end

        // R5 directed partial beat: 7 bytes give 4 then 3
        ack_mode = 1; lvl = 255;
        start(7, 32'h2000, 1);
        wait_done(100);
        chk("R5 beat count", 32'(beats), 2);

        // R13 zero length
        start(0, 32'h3000, 1);
        idle_wait(3);
        rd(A_STAT, v); chk("R13 done at zero", v, 32'h08);
        chk("R13 no beat", 32'(beats), 0);

        // R8 sticky, cleared by idle
        idle_wait(10);
        wr(A_STC, 32'h5);
        rd(A_STAT, v); chk("R8 still set", v, 32'h08);
        wr(A_CMD, 32'h0);
        rd(A_STAT, v); chk("R8 cleared by idle", v, 0);
        chk("R8 irq cleared", 32'(irq_pending), 0);

        // R6 flow control both directions
        lvl = 0;
        start(8, 32'h4000, 1);
        idle_wait(20);
        chk("R6 stall on empty fifo", 32'(beats), 0);
        lvl = 8;
        wait_done(100);
        chk("R6 write bytes", 32'(bytes), 8);
        spc = 0;
        start(8, 32'h5000, 0);
        idle_wait(20);
        chk("R6 stall on full fifo", 32'(beats), 0);
        spc = 255;
        wait_done(100);
        chk("R6 read bytes", 32'(bytes), 8);
        wr(A_CMD, 32'h0);

        // R12 core interrupt
        @(negedge clk); scsi_int = 1'b1;
        @(negedge clk); scsi_int = 1'b0;
        idle_wait(2);
        rd(A_STAT, v); chk("R12 core irq bit", v, 32'h10);
        chk("R12 irq pin", 32'(irq_pending), 1);
        wr(A_CMD, 32'h0);
        rd(A_STAT, v); chk("R8 idle clears core irq", v, 0);

        // R9 abort with a beat outstanding
        ack_mode = 0; lvl = 255;
        start(40, 32'h6000, 1);
        for (int i = 0; i < 20 && !mem_req; i++) @(negedge clk);
        wr(A_CMD, 32'h82);
        idle_wait(3);
        rd(A_STAT, v); chk("R9 waits for beat", v, 0);
        ack_mode = 1;
        idle_wait(5);
        rd(A_STAT, v); chk("R9 aborted bit", v, 32'h04);
        chk("R9 one beat", 32'(beats), 1);
        rd(A_WBC, v); chk("R9 count at boundary", v, 36);
        idle_wait(20);
        chk("R9 no more beats", 32'(beats), 1);
        chk("R7 irq on abort", 32'(irq_pending), 1);
        wr(A_CMD, 32'h0);

        // R10 memory error
        err_next = 1;
        start(40, 32'h7000, 1);
        idle_wait(20);
        rd(A_STAT, v); chk("R10 error bit", v, 32'h02);
        chk("R10 no counted beat", 32'(beats), 0);
        rd(A_CMD, v); chk("R10 command reads start", v, 32'h83);
        rd(A_WBC, v); chk("R10 count held", v, 40);
        chk("R7 irq on error", 32'(irq_pending), 1);
        wr(A_CMD, 32'h82);
        rd(A_STAT, v); chk("R10 abort after error", v, 32'h06);
        wr(A_CMD, 32'h0);

        // R11 flush of a stranded residue
        lvl = 10;
        start(16, 32'h8000, 1);
        idle_wait(30);
        chk("R11 stalled beats", 32'(beats), 2);
        rd(A_WBC, v); chk("R11 stalled count", v, 8);
        flush_mode = 1;
        wr(A_CMD, 32'h81);
        idle_wait(10);
        rd(A_STAT, v); chk("R11 flush complete", v, 32'h20);
        chk("R7 no irq on flush", 32'(irq_pending), 0);
        chk("R11 bytes flushed", 32'(bytes), 10);
        chk("R11 fifo empty", 32'(lvl), 0);
        rd(A_WAC, v); chk("R11 address advanced", v, 32'h800A);
        wr(A_CMD, 32'h0);
        e = 32'(beats);
        wr(A_CMD, 32'h81);
        idle_wait(3);
        rd(A_STAT, v); chk("R11 empty flush", v, 32'h20);
        chk("R11 empty flush no beat", 32'(beats), e);
        wr(A_CMD, 32'h0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule